// File: doc/BRIEF.md
# Global Data Window Controller

This controller sits between a processor core's data-space ports and an external memory bus. It checks every data read or write and decides whether the address falls inside a global region at the top of the data map. Accesses outside that region are local. They finish in the cycle they are presented and never touch the external bus. Accesses inside the region raise a bus request and hold the core with a stall until the external side signals ready.

The size of the global region is set at run time through an 8-bit mask register. The mask is compared with the upper byte of the address. Legal masks have their set bits packed against the most significant bit, so the region can be anything from the top 256 words up to the top 32K words of the 64K-word map. A mask of zero, or any mask with a gap in its set bits, means that no global region exists. A mask write takes effect from the clock edge that captures it. A transfer that is already waiting keeps the decision it was started with.

Top module: `gw_window_ctrl`

## Requirements
- R1: After reset the stored mask is zero, and `bus_req`, `stall` and `glob_sel` are all low.
- R2: A mask write whose value is not of the form "ones from bit 7 down, then zeros" is stored as zero. Examples are 0xA0 and 0x7F. After such a write, no address is global.
- R3: With a legal nonzero mask M, an address is global exactly when (addr[15:8] & M) == M. Two examples: mask 0x80 makes 0x8000 global and 0x7FFF local; mask 0xFF makes 0xFF00 global and 0xFEFF local.
- R4: With a zero mask, `bus_req` and `stall` never rise for any access.
- R5: A local access (`rd_en` or `wr_en` high, address not global) keeps `bus_req` and `stall` low and completes in its own cycle.
- R6: A global access presented while `ready` is high raises `bus_req` and `glob_sel` with `stall` low, so it completes with no wait state.
- R7: A global access presented while `ready` is low raises `stall` and `bus_req`. Both stay high, with `glob_sel` high, through every following cycle in which `ready` is low. The core holds the address and strobes steady during this time. In the first cycle with `ready` high, `stall` drops while `bus_req` is still high. In the next cycle `bus_req` is low unless a new global access is presented.
- R8: When `rd_en` and `wr_en` are both high, only `rd_addr` is decoded. When only `wr_en` is high, `wr_addr` is decoded.
- R9: A mask write made while a transfer is waiting does not end or change that transfer. The new mask governs the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Data read strobe |
| rd_addr | input | 16 | Data read address |
| wr_en | input | 1 | Data write strobe |
| wr_addr | input | 16 | Data write address |
| size_we | input | 1 | Mask register write enable |
| size_wdata | input | 8 | Mask register write value |
| ready | input | 1 | External global memory ready |
| bus_req | output | 1 | Global bus request strobe |
| stall | output | 1 | Hold request to the core |
| glob_sel | output | 1 | High when the decoded access is global (1) rather than local (0) |

## Verification
On every cycle, the assertions check the following:
- The stored mask always has a legal shape.
- A zero mask and a local access never produce a request or a stall.
- A stall is always followed by a held request.
- Ready always releases the stall at once.
- The address stays steady while a transfer is waiting.

Some behaviours can only be shown by the bench's scenarios: the exact boundary addresses for several mask sizes, read-over-write priority, the length of wait sequences, and a mask change landing in the middle of a waiting transfer. Each of these needs particular stimulus and expected values worked out in advance.

// File: rtl/gw_pkg.sv
package gw_pkg;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_WAIT = 1'b1
    } hs_state_e;

endpackage

// File: rtl/gw_size_reg.sv
module gw_size_reg #(
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MASK_W-1:0] wdata,
    output logic [MASK_W-1:0] mask
);

    typedef struct packed {
        logic [MASK_W-1:0] mask;
    } size_s;

    size_s s_d, s_q;
    logic  legal;

    // Legal when the inverted value is a run of ones starting at bit 0.
    always_comb begin
        legal = (((~wdata) & ((~wdata) + 1'b1)) == '0);
        s_d   = s_q;
        if (we) begin
            s_d.mask = legal ? wdata : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mask = s_q.mask;

    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (((~mask) & ((~mask) + 1'b1)) == '0)); // R2

endmodule

// File: rtl/gw_addr_decode.sv
module gw_addr_decode #(
    parameter int ADDR_W = 16,
    parameter int MASK_W = 8
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [MASK_W-1:0] mask,
    output logic              acc_valid,
    output logic              acc_hit,
    output logic [ADDR_W-1:0] sel_addr
);

    localparam int TOP_LSB = ADDR_W - MASK_W;

    logic [MASK_W-1:0] top_byte;

    always_comb begin
        sel_addr  = rd_en ? rd_addr : wr_addr;
        acc_valid = rd_en | wr_en;
        top_byte  = sel_addr[ADDR_W-1:TOP_LSB];
        acc_hit   = (mask != '0) && ((top_byte & mask) == mask);
    end

endmodule

// File: rtl/gw_handshake.sv
module gw_handshake
    import gw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    input  logic acc_hit,
    input  logic ready,
    output logic bus_req,
    output logic stall,
    output logic in_wait
);

    typedef struct packed {
        hs_state_e state;
    } hs_s;

    hs_s h_d, h_q;

    always_comb begin
        h_d     = h_q;
        in_wait = (h_q.state == HS_WAIT);
        bus_req = in_wait || (acc_valid && acc_hit);
        stall   = bus_req && !ready;
        case (h_q.state)
            HS_IDLE: if (acc_valid && acc_hit && !ready) h_d.state = HS_WAIT;
            HS_WAIT: if (ready)                          h_d.state = HS_IDLE;
            default: h_d.state = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.state <= HS_IDLE;
        end else begin
            h_q <= h_d;
        end
    end

    AST_STALL_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> bus_req); // R7
    AST_READY_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && ready) |-> !stall); // R6
    AST_WAIT_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && ready) |=> !in_wait); // R7

endmodule

// File: rtl/gw_window_ctrl.sv
module gw_window_ctrl #(
    parameter int ADDR_W = 16,
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              size_we,
    input  logic [MASK_W-1:0] size_wdata,
    input  logic              ready,
    output logic              bus_req,
    output logic              stall,
    output logic              glob_sel
);

    logic [MASK_W-1:0] mask;
    logic              acc_valid;
    logic              acc_hit;
    logic [ADDR_W-1:0] sel_addr;
    logic              in_wait;

    gw_size_reg #(.MASK_W(MASK_W)) i_size (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (size_we),
        .wdata (size_wdata),
        .mask  (mask)
    );

    gw_addr_decode #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) i_dec (
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .mask      (mask),
        .acc_valid (acc_valid),
        .acc_hit   (acc_hit),
        .sel_addr  (sel_addr)
    );

    gw_handshake i_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_hit   (acc_hit),
        .ready     (ready),
        .bus_req   (bus_req),
        .stall     (stall),
        .in_wait   (in_wait)
    );

    assign glob_sel = in_wait | acc_hit;

    AST_ZERO_MASK_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0 && !in_wait) |-> (!bus_req && !stall)); // R4
    AST_LOCAL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit && !in_wait) |-> (!bus_req && !stall)); // R5
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> $stable(sel_addr)); // R7

endmodule

// File: tb/test_gw_window_ctrl.sv
module test_gw_window_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0, size_we = 1'b0, ready = 1'b0;
    logic [15:0] rd_addr = '0, wr_addr = '0;
    logic [7:0]  size_wdata = '0;
    logic        bus_req, stall, glob_sel;
    int          total = 0, bad = 0;

    always #2.5 clk = ~clk;

    gw_window_ctrl i_gw_window_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .size_we(size_we),
        .size_wdata(size_wdata), .ready(ready), .bus_req(bus_req),
        .stall(stall), .glob_sel(glob_sel)
    );

    // exp = {bus_req, stall, glob_sel}
    task automatic chk(input string req, input logic [2:0] exp);
        total++;
        if ({bus_req, stall, glob_sel} !== exp) begin
            bad++;
            $display("FAIL %s: {req,stall,sel} actual=%b expected=%b at %0t",
                     req, {bus_req, stall, glob_sel}, exp, $time);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 0; wr_en = 0; rd_addr = '0; wr_addr = '0; ready = 0; size_we = 0;
    endtask

    task automatic set_mask(input logic [7:0] m);
        @(negedge clk);
        size_we = 1; size_wdata = m;
        @(negedge clk);
        size_we = 0;
    endtask

    task automatic present(input logic r, input logic [15:0] ra,
                           input logic w, input logic [15:0] wa, input logic rdy);
        @(negedge clk);
        rd_en = r; rd_addr = ra; wr_en = w; wr_addr = wa; ready = rdy; size_we = 0;
        #1;
    endtask

    task automatic t_reset();
        #1 chk("R1 reset outputs", 3'b000);
        present(1, 16'hFFFF, 0, 0, 1);
        chk("R1 reset mask zero", 3'b000);
        idle();
    endtask

    task automatic t_noncontig();
        set_mask(8'hA0);
        present(1, 16'hFF00, 0, 0, 1);
        chk("R2 mask A0 dropped", 3'b000);
        set_mask(8'h7F);
        present(0, 0, 1, 16'hFFFF, 0);
        chk("R2 mask 7F dropped", 3'b000);
        idle();
    endtask

    task automatic t_zero_mask();
        set_mask(8'h00);
        present(1, 16'h8000, 0, 0, 0);
        chk("R4 zero mask no request", 3'b000);
        idle();
    endtask

    task automatic t_boundary();
        set_mask(8'h80);
        present(1, 16'h8000, 0, 0, 1);
        chk("R3 mask 80 at 8000 global", 3'b101);
        present(1, 16'h7FFF, 0, 0, 1);
        chk("R5 mask 80 at 7FFF local", 3'b000);
        set_mask(8'hFF);
        present(0, 0, 1, 16'hFF00, 1);
        chk("R3 mask FF at FF00 global", 3'b101);
        present(0, 0, 1, 16'hFEFF, 0);
        chk("R5 mask FF at FEFF local no stall", 3'b000);
        idle();
    endtask

    task automatic t_wait(input int n);
        set_mask(8'hC0);
        present(0, 0, 1, 16'hC123, 0);
        chk("R7 wait start", 3'b111);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            chk("R7 wait held", 3'b111);
        end
        @(negedge clk); ready = 1; #1;
        chk("R7 ready releases stall", 3'b101);
        idle(); #1;
        chk("R7 request drops after ready", 3'b000);
    endtask

    task automatic t_zero_wait();
        set_mask(8'hE0);
        present(1, 16'hE000, 0, 0, 1);
        chk("R6 zero wait global", 3'b101);
        idle(); #1;
        chk("R6 no leftover request", 3'b000);
    endtask

    task automatic t_priority();
        set_mask(8'hC0);
        present(1, 16'h1000, 1, 16'hC000, 0);
        chk("R8 read local wins", 3'b000);
        present(1, 16'hC000, 1, 16'h1000, 1);
        chk("R8 read global wins", 3'b101);
        idle();
    endtask

    task automatic t_mask_mid_wait();
        set_mask(8'hC0);
        present(1, 16'hC000, 0, 0, 0);
        chk("R9 wait start", 3'b111);
        @(negedge clk); size_we = 1; size_wdata = 8'h00;
        @(negedge clk); size_we = 0; #1;
        chk("R9 transfer kept after mask write", 3'b111);
        @(negedge clk); ready = 1; #1;
        chk("R9 transfer completes", 3'b101);
        present(1, 16'hC000, 0, 0, 1);
        chk("R9 new mask governs next access", 3'b000);
        idle();
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #12 rst_n = 1;
        t_reset();
        t_noncontig();
        t_zero_mask();
        t_boundary();
        t_zero_wait();
        t_wait(0);
        t_wait(4);
        t_priority();
        t_mask_mid_wait();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule